// File: doc/BRIEF.md
# Horizontal Pixel Panning Unit

This block converts a 4-bit horizontal panning value into the number of pixels by which the display serialiser shifts each scan line left. How the value maps to a shift depends on the active display mode. In 9-dot text mode the shift is one larger than the value, and values of eight and above wrap to zero. In 256-colour mode the shift advances only every second value. In every other mode the shift equals the low three bits of the value.

A split-screen override can suppress panning in the lower part of the screen. When the split enable input is high, a line-compare pulse forces the shift to zero. The override stays in force until the next vertical-retrace pulse, after which the panning value applies again. The shift output is registered and is updated only on a line-start strobe, so the shift never changes in the middle of a scan line.

Top module: `hpan_unit`

## Requirements
- R1: After reset, `shift_out` is 0 and the split override is inactive.
- R2: With `disp_mode` = 2'b00 (9-dot text) and `pan_val` from 0 to 7, a line-start strobe loads `pan_val`+1 into `shift_out`.
- R3: With `disp_mode` = 2'b00 and `pan_val` from 8 to 15, a line-start strobe loads 0.
- R4: With `disp_mode` = 2'b01 (256-colour), a line-start strobe loads `pan_val[2:0]` divided by two, rounded down. Values 0, 2, 4 and 6 give 0, 1, 2 and 3, and bit 3 is ignored.
- R5: With `disp_mode` = 2'b10 or 2'b11 (other modes), a line-start strobe loads `pan_val[2:0]`.
- R6: `shift_out` changes only in the cycle after `line_start` is high. Changes to `pan_val` or `disp_mode` without a strobe leave it unchanged.
- R7: When `split_en` is high, a `line_cmp` pulse sets the override. Every later strobe then loads 0 until a retrace clears the override.
- R8: A `vretrace` pulse clears the override, and the next strobe loads the mode-mapped value again.
- R9: If `line_cmp` and `vretrace` are high in the same cycle, the override ends up cleared.
- R10: When `split_en` is low, `line_cmp` has no effect on `shift_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pan_val | input | 4 | Horizontal panning value |
| disp_mode | input | 2 | 00 = 9-dot text, 01 = 256-colour, 10/11 = other |
| split_en | input | 1 | Enables the split-screen panning override |
| line_cmp | input | 1 | Line-compare match pulse |
| vretrace | input | 1 | Vertical-retrace pulse |
| line_start | input | 1 | Scan-line start strobe; loads the shift |
| shift_out | output | 4 | Effective left pixel shift for the serialiser |

## Verification
The properties assume that `pan_val`, `disp_mode` and `split_en` are stable quantities sampled at a line-start strobe. They also assume that the line-compare and retrace inputs are single-cycle pulses. The mapping properties only judge a strobe when the override is not active. The stimulus changes inputs only on the falling clock edge, issues each strobe as a one-cycle pulse, and separates every override event from the strobes that observe it by at least one cycle. The only exception is the deliberate case where both pulses arrive together.

// File: rtl/hpan_pkg.sv
package hpan_pkg;
   localparam int unsigned LOW_W   = 3;
   localparam int unsigned SHIFT_W = 4;

   typedef enum logic [1:0] {
      MODE_TEXT9  = 2'b00,
      MODE_PIX256 = 2'b01,
      MODE_OTHER  = 2'b10,
      MODE_OTHER2 = 2'b11
   } pan_mode_e;
endpackage

// File: rtl/hpan_decode.sv
module hpan_decode #(
   parameter int unsigned REG_W = 4
) (
   input  logic [REG_W-1:0]                pan_val,
   input  hpan_pkg::pan_mode_e             mode,
   output logic [hpan_pkg::SHIFT_W-1:0]    shift
);
   import hpan_pkg::*;

   logic [LOW_W-1:0] low;
   logic             upper_set;

   assign low       = pan_val[LOW_W-1:0];
   assign upper_set = |pan_val[REG_W-1:LOW_W];

   always_comb begin
      unique case (mode)
         MODE_TEXT9:  shift = upper_set ? '0 : (SHIFT_W'(low) + SHIFT_W'(1));
         MODE_PIX256: shift = SHIFT_W'(low[LOW_W-1:1]);
         default:     shift = SHIFT_W'(low);
      endcase
   end
endmodule

// File: rtl/hpan_split.sv
module hpan_split (
   input  logic clk,
   input  logic rst_n,
   input  logic split_en,
   input  logic line_cmp,
   input  logic vretrace,
   output logic flag_q,
   output logic force_zero
);
   always_ff @(posedge clk) begin
      if (!rst_n)                     flag_q <= 1'b0;
      else if (vretrace)              flag_q <= 1'b0;
      else if (line_cmp && split_en)  flag_q <= 1'b1;
   end

   assign force_zero = flag_q & split_en;
endmodule

// File: rtl/hpan_hold.sv
module hpan_hold #(
   parameter int unsigned W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         force_zero,
   input  logic [W-1:0] next_val,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)     q <= '0;
      else if (load)  q <= force_zero ? '0 : next_val;
   end
endmodule

// File: rtl/hpan_unit.sv
module hpan_unit #(
   parameter int unsigned REG_W         = 4,
   parameter bit          SPLIT_SUPPORT = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [REG_W-1:0]              pan_val,
   input  logic [1:0]                    disp_mode,
   input  logic                          split_en,
   input  logic                          line_cmp,
   input  logic                          vretrace,
   input  logic                          line_start,
   output logic [hpan_pkg::SHIFT_W-1:0]  shift_out
);
   import hpan_pkg::*;

   if (REG_W < 4 || REG_W > 8) begin : g_bad_width
      $error("hpan_unit: REG_W must lie in 4..8");
   end

   logic [SHIFT_W-1:0] mapped;
   logic               ovr_q;
   logic               force_zero;

   hpan_decode #(.REG_W(REG_W)) u_decode (
      .pan_val (pan_val),
      .mode    (pan_mode_e'(disp_mode)),
      .shift   (mapped)
   );

   if (SPLIT_SUPPORT) begin : g_split
      hpan_split u_split (
         .clk        (clk),
         .rst_n      (rst_n),
         .split_en   (split_en),
         .line_cmp   (line_cmp),
         .vretrace   (vretrace),
         .flag_q     (ovr_q),
         .force_zero (force_zero)
      );
   end else begin : g_nosplit
      assign ovr_q      = 1'b0;
      assign force_zero = 1'b0;
   end

   hpan_hold #(.W(SHIFT_W)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (line_start),
      .force_zero (force_zero),
      .next_val   (mapped),
      .q          (shift_out)
   );
endmodule

// File: rtl/hpan_unit_chk.sv
module hpan_unit_chk #(
   parameter int unsigned REG_W = 4
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [REG_W-1:0]              pan_val,
   input logic [1:0]                    disp_mode,
   input logic                          split_en,
   input logic                          line_cmp,
   input logic                          vretrace,
   input logic                          line_start,
   input logic                          ovr_q,
   input logic [hpan_pkg::SHIFT_W-1:0]  shift_out
);
   import hpan_pkg::*;

   p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !line_start |=> $stable(shift_out));

   p_text_plus_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && disp_mode == 2'b00 && pan_val[REG_W-1:3] == '0 && !(split_en && ovr_q))
      |=> shift_out == SHIFT_W'($past(pan_val[2:0])) + SHIFT_W'(1));

   p_text_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && disp_mode == 2'b00 && pan_val[REG_W-1:3] != '0) |=> shift_out == '0);

   p_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && disp_mode == 2'b01 && !(split_en && ovr_q))
      |=> shift_out == SHIFT_W'($past(pan_val[2:1])));

   p_other_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && disp_mode[1] && !(split_en && ovr_q))
      |=> shift_out == SHIFT_W'($past(pan_val[2:0])));

   p_force_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && split_en && ovr_q) |=> shift_out == '0);

   p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (line_cmp && split_en && !vretrace) |=> ovr_q);

   p_clear_r8_r9: assert property (@(posedge clk) disable iff (!rst_n)
      vretrace |=> !ovr_q);

   p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      shift_out <= SHIFT_W'(8));
endmodule

bind hpan_unit hpan_unit_chk #(.REG_W(REG_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pan_val    (pan_val),
   .disp_mode  (disp_mode),
   .split_en   (split_en),
   .line_cmp   (line_cmp),
   .vretrace   (vretrace),
   .line_start (line_start),
   .ovr_q      (ovr_q),
   .shift_out  (shift_out)
);

// File: tb/hpan_unit_test.sv
`timescale 1ns/1ps
module hpan_unit_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] pan_val = '0;
   logic [1:0] disp_mode = '0;
   logic       split_en = 1'b0;
   logic       line_cmp = 1'b0;
   logic       vretrace = 1'b0;
   logic       line_start = 1'b0;
   logic [3:0] shift_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [3:0] exp_q[$];
   string      tag_q[$];

   always #10 clk = ~clk;

   hpan_unit uut (
      .clk(clk), .rst_n(rst_n), .pan_val(pan_val), .disp_mode(disp_mode),
      .split_en(split_en), .line_cmp(line_cmp), .vretrace(vretrace),
      .line_start(line_start), .shift_out(shift_out)
   );

   function automatic logic [3:0] model(input logic [3:0] v, input logic [1:0] m);
      if (m == 2'b00)      return (v >= 4'd8) ? 4'd0 : v + 4'd1;
      else if (m == 2'b01) return {2'b00, v[2:1]};
      else                 return {1'b0, v[2:0]};
   endfunction

   task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // driver: one strobe, expected value pushed to the scoreboard
   task automatic strobe(input logic [3:0] v, input logic [1:0] m,
                         input logic [3:0] exp, input string tag);
      @(negedge clk);
      pan_val = v; disp_mode = m; line_start = 1'b1;
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
      line_start = 1'b0;
   endtask

   task automatic pulse(input logic cmp, input logic ret);
      @(negedge clk);
      line_cmp = cmp; vretrace = ret;
      @(negedge clk);
      line_cmp = 1'b0; vretrace = 1'b0;
   endtask

   // monitor: pop and compare after every strobed edge
   initial begin
      forever begin
         logic ls;
         @(posedge clk);
         ls = line_start;
         #5;
         if (ls && exp_q.size() > 0) check(tag_q.pop_front(), shift_out, exp_q.pop_front());
      end
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual hung expected done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset shift", shift_out, 4'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2, R3, R4, R5: full sweep in every mode
      for (int m = 0; m < 4; m++) begin
         for (int v = 0; v < 16; v++) begin
            string t;
            if (m == 0)      t = (v < 8) ? "R2 text plus one" : "R3 text wrap";
            else if (m == 1) t = "R4 256-colour half";
            else             t = "R5 other low bits";
            strobe(4'(v), 2'(m), model(4'(v), 2'(m)), t);
         end
      end

      // R1: override is inactive after reset (enabled split, no compare seen)
      split_en = 1'b1;
      strobe(4'd5, 2'b10, 4'd5, "R1 override clear after reset");

      // R6: no strobe, inputs change, output holds
      strobe(4'd3, 2'b10, 4'd3, "R6 setup");
      @(negedge clk);
      pan_val = 4'd6; disp_mode = 2'b00;
      repeat (3) @(negedge clk);
      check("R6 hold without strobe", shift_out, 4'd3);

      // R7: compare sets override
      pulse(1'b1, 1'b0);
      strobe(4'd4, 2'b00, 4'd0, "R7 forced zero text");
      strobe(4'd6, 2'b10, 4'd0, "R7 forced zero other");
      repeat (2) @(negedge clk);
      check("R7 still zero between lines", shift_out, 4'd0);

      // R8: retrace clears
      pulse(1'b0, 1'b1);
      strobe(4'd4, 2'b00, 4'd5, "R8 restored text");
      strobe(4'd6, 2'b01, 4'd3, "R8 restored 256-colour");

      // R9: both together, retrace wins
      pulse(1'b1, 1'b1);
      strobe(4'd7, 2'b10, 4'd7, "R9 retrace wins");

      // R10: split disabled, compare ignored
      split_en = 1'b0;
      pulse(1'b1, 1'b0);
      strobe(4'd2, 2'b10, 4'd2, "R10 compare ignored other");
      strobe(4'd7, 2'b00, 4'd8, "R10 compare ignored text");
      check("R10 output after ignored compare", shift_out, 4'd8);

      repeat (3) @(negedge clk);
      check("scoreboard drained", 4'(exp_q.size()), 4'd0);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule